// File: doc/BRIEF.md
# Banked Memory-Map Chip-Select Decoder

This block turns every bus cycle of an 8-bit processor with a 64 KiB address space into chip selects for one RAM, two system ROMs, a character ROM and an I/O block. Three bank bits set which devices cover RAM. Those bits sit in a small register that the processor loads by writing to address 0x0001. In the covered windows, reads go to the covering device. Writes to a ROM window still reach the RAM underneath, so software can fill RAM while it runs from ROM.

A second, independent decode serves the video fetch port. That port takes the character ROM in two fixed 4 KiB slots and RAM everywhere else. The processor banking has no effect on it. All decode is combinational from the address, the direction and the current bank bits. The only state is the bank register.

Bank bits: bit 0 `lo_map`, bit 1 `hi_map`, bit 2 `io_over_chr`. At reset all three are 1.

Top module: `mm_decoder`

## Requirements
- R1: After reset the bank bits are 3'b111. With no bank write, a read at 0xA000 selects the low ROM, a read at 0xE000 selects the high ROM, and a read at 0xD000 selects I/O.
- R2: A valid write to address 0x0001 loads `cpu_wdata[2:0]` into the bank bits at that clock edge. The decode uses the new value from the next cycle on. The write itself selects RAM (`ram_cs`=1, `ram_we`=1).
- R3: A read in 0xA000–0xBFFF selects the low ROM (`rom_lo_cs`=1, RAM off) when `lo_map` and `hi_map` are both 1. Otherwise it selects RAM with `ram_oe`=1.
- R4: A read in 0xE000–0xFFFF selects the high ROM when `hi_map` is 1. Otherwise it selects RAM with `ram_oe`=1.
- R5: A write in either ROM window always selects RAM with `ram_we`=1 and `ram_oe`=0. No ROM select is raised.
- R6: In 0xD000–0xDFFF, when (`lo_map` or `hi_map`) is 1 and `io_over_chr` is 1, reads and writes raise `io_cs`, and RAM is not selected.
- R7: In 0xD000–0xDFFF, when (`lo_map` or `hi_map`) is 1 and `io_over_chr` is 0, reads raise `chr_cs` and writes select RAM with `ram_we`=1.
- R8: In 0xD000–0xDFFF, when `lo_map` and `hi_map` are both 0, reads and writes select RAM.
- R9: Every other address selects RAM. `ram_oe` is 1 on reads and `ram_we` is 1 on writes.
- R10: At most one of `ram_cs`, `rom_lo_cs`, `rom_hi_cs`, `chr_cs`, `io_cs` is 1 in any cycle. All five, plus `ram_oe` and `ram_we`, are 0 while `cpu_valid` is 0.
- R11: A video fetch raises `vid_chr_cs` when its upper address nibble `vid_page` is 0x1 or 0x9. Otherwise it raises `vid_ram_cs`. Exactly one of the two is 1, and the result does not depend on the bank bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_valid | input | 1 | Processor cycle is valid |
| cpu_wdata | input | 3 | Low data bits, the bank value on a write to 0x0001 |
| vid_page | input | 4 | Upper address nibble of the video fetch |
| ram_cs | output | 1 | RAM select, processor side |
| ram_oe | output | 1 | RAM output enable (read) |
| ram_we | output | 1 | RAM write enable |
| rom_lo_cs | output | 1 | Low system ROM select |
| rom_hi_cs | output | 1 | High system ROM select |
| chr_cs | output | 1 | Character ROM select, processor side |
| io_cs | output | 1 | I/O block select |
| vid_ram_cs | output | 1 | RAM select, video side |
| vid_chr_cs | output | 1 | Character ROM select, video side |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a bank register at 0x0001, and windows at 0xA, 0xD and 0xE. That way each of the sixteen 4 KiB slots can be visited under each of the eight bank values, in both directions. The reference model tracks the bank bits by itself and compares every output every cycle. This covers the overlay boundaries at 0x9FFF/0xA000 and 0xBFFF/0xC000, cycles with the valid strobe low, and video fetches under banking values that hide the character ROM from the processor.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int CFG_W = 3;

    typedef struct packed {
        logic io_over_chr;
        logic hi_map;
        logic lo_map;
    } bank_cfg_t;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_RAM,
        RGN_LOROM,
        RGN_HIROM,
        RGN_CHR,
        RGN_IO
    } region_e;
endpackage

// File: rtl/mm_bank_reg.sv
module mm_bank_reg
    import mm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              cpu_valid,
    input  logic [CFG_W-1:0]  cpu_wdata,
    output bank_cfg_t         cfg
);
    logic load;
    assign load = cpu_valid && cpu_we && (cpu_addr == CFG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg <= '1;
        else if (load)
            cfg <= bank_cfg_t'(cpu_wdata);
    end

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cfg == $past(cpu_wdata)));
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg));
endmodule

// File: rtl/mm_cpu_decode.sv
module mm_cpu_decode
    import mm_pkg::*;
#(
    parameter int SLOT_W = 4,
    parameter logic [SLOT_W-2:0] LO_PAGE = 3'd5,
    parameter logic [SLOT_W-2:0] HI_PAGE = 3'd7,
    parameter logic [SLOT_W-1:0] IO_SLOT = 4'hD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot,
    input  logic              cpu_we,
    input  logic              cpu_valid,
    input  bank_cfg_t         cfg,
    output logic              ram_cs,
    output logic              ram_oe,
    output logic              ram_we,
    output logic              rom_lo_cs,
    output logic              rom_hi_cs,
    output logic              chr_cs,
    output logic              io_cs
);
    region_e rgn;
    logic    rd;
    logic    d_win_mapped;

    assign rd           = !cpu_we;
    assign d_win_mapped = cfg.lo_map | cfg.hi_map;

    always_comb begin
        if (!cpu_valid)
            rgn = RGN_NONE;
        else if (slot[SLOT_W-1:1] == LO_PAGE && rd && cfg.lo_map && cfg.hi_map)
            rgn = RGN_LOROM;
        else if (slot[SLOT_W-1:1] == HI_PAGE && rd && cfg.hi_map)
            rgn = RGN_HIROM;
        else if (slot == IO_SLOT && d_win_mapped && cfg.io_over_chr)
            rgn = RGN_IO;
        else if (slot == IO_SLOT && d_win_mapped && rd)
            rgn = RGN_CHR;
        else
            rgn = RGN_RAM;
    end

    always_comb begin
        ram_cs    = 1'b0;
        ram_oe    = 1'b0;
        ram_we    = 1'b0;
        rom_lo_cs = 1'b0;
        rom_hi_cs = 1'b0;
        chr_cs    = 1'b0;
        io_cs     = 1'b0;
        unique case (rgn)
            RGN_NONE:  ;
            RGN_RAM: begin
                ram_cs = 1'b1;
                ram_oe = rd;
                ram_we = cpu_we;
            end
            RGN_LOROM: rom_lo_cs = 1'b1;
            RGN_HIROM: rom_hi_cs = 1'b1;
            RGN_CHR:   chr_cs    = 1'b1;
            RGN_IO:    io_cs     = 1'b1;
            default:   ;
        endcase
    end

    assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs, rom_lo_cs, rom_hi_cs, chr_cs, io_cs}));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |-> !(ram_cs | ram_oe | ram_we | rom_lo_cs | rom_hi_cs | chr_cs | io_cs));
    assert_write_no_rom_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |-> !(rom_lo_cs | rom_hi_cs | chr_cs | ram_oe));
    assert_io_hides_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
        io_cs |-> (!ram_cs && cfg.io_over_chr));
endmodule

// File: rtl/mm_vid_decode.sv
module mm_vid_decode #(
    parameter int SLOT_W = 4,
    parameter logic [SLOT_W-1:0] CHR_SLOT_A = 4'h1,
    parameter logic [SLOT_W-1:0] CHR_SLOT_B = 4'h9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] vid_page,
    output logic              vid_ram_cs,
    output logic              vid_chr_cs
);
    always_comb begin
        vid_chr_cs = (vid_page == CHR_SLOT_A) || (vid_page == CHR_SLOT_B);
        vid_ram_cs = !vid_chr_cs;
    end

    assert_vid_exactly_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({vid_ram_cs, vid_chr_cs}));
endmodule

// File: rtl/mm_decoder.sv
module mm_decoder
    import mm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h0001,
    parameter logic [2:0] LO_PAGE = 3'd5,
    parameter logic [2:0] HI_PAGE = 3'd7,
    parameter logic [3:0] IO_SLOT = 4'hD,
    parameter logic [3:0] CHR_SLOT_A = 4'h1,
    parameter logic [3:0] CHR_SLOT_B = 4'h9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              cpu_valid,
    input  logic [CFG_W-1:0]  cpu_wdata,
    input  logic [3:0]        vid_page,
    output logic              ram_cs,
    output logic              ram_oe,
    output logic              ram_we,
    output logic              rom_lo_cs,
    output logic              rom_hi_cs,
    output logic              chr_cs,
    output logic              io_cs,
    output logic              vid_ram_cs,
    output logic              vid_chr_cs
);
    localparam int SLOT_W = 4;
    localparam int SLOT_LSB = ADDR_W - SLOT_W;

    bank_cfg_t cfg;

    mm_bank_reg #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) bank_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_valid(cpu_valid), .cpu_wdata(cpu_wdata), .cfg(cfg)
    );

    mm_cpu_decode #(.SLOT_W(SLOT_W), .LO_PAGE(LO_PAGE), .HI_PAGE(HI_PAGE),
                    .IO_SLOT(IO_SLOT)) cpu_i (
        .clk(clk), .rst_n(rst_n), .slot(cpu_addr[ADDR_W-1:SLOT_LSB]),
        .cpu_we(cpu_we), .cpu_valid(cpu_valid), .cfg(cfg),
        .ram_cs(ram_cs), .ram_oe(ram_oe), .ram_we(ram_we),
        .rom_lo_cs(rom_lo_cs), .rom_hi_cs(rom_hi_cs),
        .chr_cs(chr_cs), .io_cs(io_cs)
    );

    mm_vid_decode #(.SLOT_W(SLOT_W), .CHR_SLOT_A(CHR_SLOT_A),
                    .CHR_SLOT_B(CHR_SLOT_B)) vid_i (
        .clk(clk), .rst_n(rst_n), .vid_page(vid_page),
        .vid_ram_cs(vid_ram_cs), .vid_chr_cs(vid_chr_cs)
    );
endmodule

// File: tb/mm_decoder_tb.sv
module mm_decoder_tb_top;
    localparam int CLK_P = 10;
    localparam int WATCHDOG_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic        cpu_valid = 1'b0;
    logic [2:0]  cpu_wdata = '0;
    logic [3:0]  vid_page = '0;
    logic ram_cs, ram_oe, ram_we, rom_lo_cs, rom_hi_cs, chr_cs, io_cs;
    logic vid_ram_cs, vid_chr_cs;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;
    logic [2:0] model_cfg = 3'b111;

    always #(CLK_P/2) clk = ~clk;

    mm_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_valid(cpu_valid), .cpu_wdata(cpu_wdata), .vid_page(vid_page),
        .ram_cs(ram_cs), .ram_oe(ram_oe), .ram_we(ram_we),
        .rom_lo_cs(rom_lo_cs), .rom_hi_cs(rom_hi_cs), .chr_cs(chr_cs),
        .io_cs(io_cs), .vid_ram_cs(vid_ram_cs), .vid_chr_cs(vid_chr_cs)
    );

    // Expected {ram_cs,ram_oe,ram_we,rom_lo,rom_hi,chr,io,vid_ram,vid_chr}
    function automatic logic [8:0] expect_vec(int a, bit we, bit v, int vp, logic [2:0] c);
        bit ram = 0, lo = 0, hi = 0, chr = 0, io = 0, vchr;
        int s = a / 4096;
        bit rd = !we;
        bit dmap = c[0] || c[1];
        if (v) begin
            if ((s == 10 || s == 11) && rd && c[0] && c[1]) lo = 1;
            else if (s >= 14 && rd && c[1]) hi = 1;
            else if (s == 13 && dmap && c[2]) io = 1;
            else if (s == 13 && dmap && rd) chr = 1;
            else ram = 1;
        end
        vchr = (vp == 1) || (vp == 9);
        return {ram, ram && rd, ram && we, lo, hi, chr, io, !vchr, vchr};
    endfunction

    task automatic step(input int a, input bit we, input bit v, input logic [2:0] wd,
                        input int vp, input string tag);
        logic [8:0] exp_v, act;
        @(negedge clk);
        cpu_addr = a[15:0]; cpu_we = we; cpu_valid = v; cpu_wdata = wd; vid_page = vp[3:0];
        #1;
        exp_v = expect_vec(a, we, v, vp, model_cfg);
        act = {ram_cs, ram_oe, ram_we, rom_lo_cs, rom_hi_cs, chr_cs, io_cs, vid_ram_cs, vid_chr_cs};
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s addr=%h we=%0b v=%0b vp=%h cfg=%b actual=%b expected=%b",
                     tag, a[15:0], we, v, vp[3:0], model_cfg, act, exp_v);
        end
        @(posedge clk);
        if (v && we && a == 1) model_cfg = wd;
    endtask

    task automatic set_cfg(input logic [2:0] c);
        step(16'h0001, 1'b1, 1'b1, c, 0, "R2");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset banking shows both ROMs and I/O
        step(16'hA000, 0, 1, 0, 0, "R1");
        step(16'hE000, 0, 1, 0, 0, "R1");
        step(16'hD000, 0, 1, 0, 0, "R1");
        // R10: idle cycles raise nothing
        step(16'hA000, 0, 0, 0, 2, "R10");
        step(16'hD000, 1, 0, 0, 9, "R10");
        // R2: the write to the bank address itself hits RAM; the new value applies next cycle
        set_cfg(3'b010);
        step(16'hA000, 0, 1, 0, 0, "R2_R3");
        step(16'hE000, 0, 1, 0, 0, "R2_R4");
        // R2: a write elsewhere or an idle cycle at 0x0001 does not load
        step(16'h0002, 1, 1, 3'b000, 0, "R2");
        step(16'h0001, 1, 0, 3'b000, 0, "R2");
        step(16'hE000, 0, 1, 0, 0, "R2");
        // Full sweep: every bank value, every slot, both directions
        for (int c = 0; c < 8; c++) begin
            set_cfg(c[2:0]);
            for (int s = 0; s < 16; s++) begin
                string t;
                if (s == 10 || s == 11) t = "R3_R5";
                else if (s >= 14) t = "R4_R5";
                else if (s == 13) t = "R6_R7_R8";
                else t = "R9";
                step(s * 4096, 0, 1, 0, s, t);
                step(s * 4096 + 4095, 1, 1, 0, 15 - s, t);
            end
        end
        // Window edges under the reset banking
        set_cfg(3'b111);
        step(16'h9FFF, 0, 1, 0, 0, "R3_R9");
        step(16'hBFFF, 0, 1, 0, 0, "R3");
        step(16'hC000, 0, 1, 0, 0, "R9");
        step(16'hDFFF, 1, 1, 0, 0, "R6");
        // R7: character ROM on reads, RAM on writes
        set_cfg(3'b011);
        step(16'hD800, 0, 1, 0, 0, "R7");
        step(16'hD800, 1, 1, 0, 0, "R7");
        // R11: video fetches ignore the banking, including when the ROM is hidden from the CPU
        set_cfg(3'b111);
        for (int p = 0; p < 16; p++) step(16'hD000, 0, 1, 0, p, "R11");
        set_cfg(3'b000);
        for (int p = 0; p < 16; p++) step(16'h1000, 0, 1, 0, p, "R11");
        done = 1;
    end

    initial begin
        while (!done && cycles < WATCHDOG_CYC) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule